// File: doc/BRIEF.md
# Cascaded BCD Stopwatch Time Base

This block is the counting core of a stopwatch. A single clock runs it, and a one-cycle enable pulse paces it. That pulse comes from an external oscillator divider at the rate of one hundredth of a second. Four counters are chained: hundredths, seconds, minutes and hours. Each counter holds two BCD digits. A stage advances only on a cycle where the stage below it hands over a carry. A carry is the enable of the lower stage, qualified by that stage sitting at its top value.

Each stage also keeps a sticky flag that sets the first time the stage wraps. Display logic outside this block can read these flags to pick the highest unit that is actually counting. Every value and flag output can be inverted by one polarity input, which suits active-low display hardware. The moduli are parameters. The defaults are 100, 60, 60 and 24. A stage modulus of ten or less builds a single-digit variant whose tens digit is tied to zero.

Top module: `chrono_chain`

## Requirements
- R1: While `rst` is high at a clock edge, all four counters go to 00 and all four wrap flags go to 0. The polarity input still applies to the outputs during reset.
- R2: On a cycle with `tick_i` low, no counter value and no flag changes.
- R3: The hundredths counter steps by one on each tick through 00..99 (HUND_MOD-1). On the tick at its top value it returns to 00 and carries into seconds.
- R4: The seconds counter steps only on a hundredths carry, through 00..59 (SEC_MOD-1). At its top value it returns to 00 and carries into minutes.
- R5: The minutes counter steps only on a seconds carry, through 00..59 (MIN_MOD-1). At its top value it returns to 00 and carries into hours.
- R6: The hours counter steps only on a minutes carry, through 00..23 (HR_MOD-1). The tick taken at 23:59:59.99 returns all four counters to 00.
- R7: Each byte output holds the tens digit in bits 7:4 and the units digit in bits 3:0. Neither digit ever shows a code above 9.
- R8: `wrapped_o` bit 0 belongs to hundredths, bit 1 to seconds, bit 2 to minutes and bit 3 to hours. A bit sets on the tick that wraps its stage and stays set until reset, even while the stage reads 00.
- R9: With `active_low_i` high, every bit of the four value outputs and of `wrapped_o` is the inverse of its active-high value. The inversion takes effect combinationally, with no clock edge needed.
- R10: A tick sampled at a clock edge shows up on the outputs right after that same edge, with no extra pipeline cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle hundredths enable from the divider |
| active_low_i | input | 1 | High inverts all value and flag outputs |
| hund_o | output | 8 | Hundredths, two BCD digits |
| sec_o | output | 8 | Seconds, two BCD digits |
| min_o | output | 8 | Minutes, two BCD digits |
| hr_o | output | 8 | Hours, two BCD digits |
| wrapped_o | output | 4 | Sticky per-stage wrap flags |

## Verification
Every counter and flag is one register away from `tick_i`. The effect of a tick that the design samples at a rising edge is therefore due just after that edge. The bench drives `tick_i` at a falling edge and compares all outputs at the following falling edge, half a period after the sampling edge. It never looks two edges later. The polarity input reaches the outputs through logic alone, so its checks are made within the same low phase in which it changes, after a short settling delay.

// File: rtl/chrono_pkg.sv
package chrono_pkg;
   localparam int unsigned NUM_STAGES = 4;
   localparam int unsigned DIGIT_W    = 4;
   localparam int unsigned PAIR_W     = 2 * DIGIT_W;
   localparam int unsigned STG_HUND   = 0;
   localparam int unsigned STG_SEC    = 1;
   localparam int unsigned STG_MIN    = 2;
   localparam int unsigned STG_HR     = 3;
   typedef logic [PAIR_W-1:0] bcd_pair_t;
endpackage

// File: rtl/chrono_bcd_stage.sv
module chrono_bcd_stage
   import chrono_pkg::*;
#(
   parameter int unsigned MODULUS = 60
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      en_i,
   output bcd_pair_t value_o,
   output logic      carry_o
);
   localparam logic [DIGIT_W-1:0] TOP_LO = DIGIT_W'((MODULUS - 1) % 10);
   localparam logic [DIGIT_W-1:0] TOP_HI = DIGIT_W'((MODULUS - 1) / 10);

   logic [DIGIT_W-1:0] lo_q;
   logic [DIGIT_W-1:0] hi_q;
   logic               at_top;

   generate
      if (MODULUS < 2 || MODULUS > 100) begin : g_bad_modulus
         $error("chrono_bcd_stage: MODULUS must lie in 2..100");
      end

      if (MODULUS <= 10) begin : g_one_digit
         assign hi_q   = '0;
         assign at_top = (lo_q == TOP_LO);
         always_ff @(posedge clk) begin
            if (rst) begin
               lo_q <= '0;
            end else if (en_i) begin
               lo_q <= at_top ? '0 : lo_q + 1'b1;
            end
         end
      end else begin : g_two_digit
         logic [DIGIT_W-1:0] hi_r;
         assign hi_q   = hi_r;
         assign at_top = (lo_q == TOP_LO) && (hi_r == TOP_HI);
         always_ff @(posedge clk) begin
            if (rst) begin
               lo_q <= '0;
               hi_r <= '0;
            end else if (en_i) begin
               if (at_top) begin
                  lo_q <= '0;
                  hi_r <= '0;
               end else if (lo_q == DIGIT_W'(9)) begin
                  lo_q <= '0;
                  hi_r <= hi_r + 1'b1;
               end else begin
                  lo_q <= lo_q + 1'b1;
               end
            end
         end
      end
   endgenerate

   assign value_o = {hi_q, lo_q};
   assign carry_o = en_i & at_top;
endmodule

// File: rtl/chrono_wrap_flags.sv
module chrono_wrap_flags #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] carry_i,
   output logic [N-1:0] flags_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("chrono_wrap_flags: N must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) flags_o <= '0;
      else     flags_o <= flags_o | carry_i;
   end
endmodule

// File: rtl/chrono_out_pol.sv
module chrono_out_pol #(
   parameter int unsigned W = 8
) (
   input  logic         active_low_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("chrono_out_pol: W must be at least 1");
      end
   endgenerate

   assign q_o = d_i ^ {W{active_low_i}};
endmodule

// File: rtl/chrono_chain.sv
module chrono_chain
   import chrono_pkg::*;
#(
   parameter int unsigned HUND_MOD = 100,
   parameter int unsigned SEC_MOD  = 60,
   parameter int unsigned MIN_MOD  = 60,
   parameter int unsigned HR_MOD   = 24
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick_i,
   input  logic       active_low_i,
   output logic [7:0] hund_o,
   output logic [7:0] sec_o,
   output logic [7:0] min_o,
   output logic [7:0] hr_o,
   output logic [3:0] wrapped_o
);
   localparam int unsigned BUS_W = NUM_STAGES * PAIR_W + NUM_STAGES;

   function automatic int unsigned mod_of(input int unsigned k);
      case (k)
         STG_HUND: return HUND_MOD;
         STG_SEC:  return SEC_MOD;
         STG_MIN:  return MIN_MOD;
         default:  return HR_MOD;
      endcase
   endfunction

   logic [NUM_STAGES-1:0]             stage_en;
   logic [NUM_STAGES-1:0]             stage_carry;
   logic [NUM_STAGES-1:0][PAIR_W-1:0] raw_val;
   logic [NUM_STAGES-1:0]             raw_wrap;
   logic [BUS_W-1:0]                  pol_bus;

   assign stage_en = {stage_carry[NUM_STAGES-2:0], tick_i};

   generate
      for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
         chrono_bcd_stage #(.MODULUS(mod_of(g))) u_stg (
            .clk     (clk),
            .rst     (rst),
            .en_i    (stage_en[g]),
            .value_o (raw_val[g]),
            .carry_o (stage_carry[g])
         );
      end
   endgenerate

   chrono_wrap_flags #(.N(NUM_STAGES)) u_flags (
      .clk     (clk),
      .rst     (rst),
      .carry_i (stage_carry),
      .flags_o (raw_wrap)
   );

   chrono_out_pol #(.W(BUS_W)) u_pol (
      .active_low_i (active_low_i),
      .d_i          ({raw_wrap, raw_val}),
      .q_o          (pol_bus)
   );

   assign hund_o    = pol_bus[STG_HUND*PAIR_W +: PAIR_W];
   assign sec_o     = pol_bus[STG_SEC*PAIR_W  +: PAIR_W];
   assign min_o     = pol_bus[STG_MIN*PAIR_W  +: PAIR_W];
   assign hr_o      = pol_bus[STG_HR*PAIR_W   +: PAIR_W];
   assign wrapped_o = pol_bus[BUS_W-1 -: NUM_STAGES];
endmodule

// File: rtl/chrono_chain_chk.sv
module chrono_chain_chk #(
   parameter int unsigned HUND_MOD = 100,
   parameter int unsigned HR_MOD   = 24
) (
   input logic             clk,
   input logic             rst,
   input logic             tick,
   input logic [3:0][7:0]  raw_val,
   input logic [3:0]       raw_wrap
);
   localparam logic [7:0] H_TOP  = {4'((HUND_MOD - 1) / 10), 4'((HUND_MOD - 1) % 10)};
   localparam logic [7:0] HR_TOP = {4'((HR_MOD - 1) / 10), 4'((HR_MOD - 1) % 10)};

   generate
      for (genvar n = 0; n < 8; n++) begin : g_nib
         // R7
         digit_range_chk: assert property (@(posedge clk) disable iff (rst)
            raw_val[n/2][(n%2)*4 +: 4] <= 4'd9);
      end
   endgenerate

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !tick |=> ($stable(raw_val) && $stable(raw_wrap)));

   // R3
   hund_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && raw_val[0] == H_TOP) |=> (raw_val[0] == 8'h00 && raw_wrap[0]));

   // R3
   hund_step_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && raw_val[0] != H_TOP) |=> (raw_val[0] != $past(raw_val[0])));

   // R4
   upper_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !(tick && raw_val[0] == H_TOP) |=> $stable(raw_val[3:1]));

   // R6
   hr_range_chk: assert property (@(posedge clk) disable iff (rst)
      raw_val[3] <= HR_TOP);

   // R8
   sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (raw_wrap != 4'b0) |=> ((raw_wrap & $past(raw_wrap)) == $past(raw_wrap)));
endmodule

bind chrono_chain chrono_chain_chk #(.HUND_MOD(HUND_MOD), .HR_MOD(HR_MOD)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .tick     (tick_i),
   .raw_val  (raw_val),
   .raw_wrap (raw_wrap)
);

// File: tb/sim_chrono_chain.sv
`timescale 1ns/100ps
module sim_chrono_chain;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst = 1'b1;
   logic tick0 = 1'b0, tick1 = 1'b0;
   logic pol0 = 1'b0, pol1 = 1'b0;
   logic [7:0] h0, s0, m0, r0, h1, s1, m1, r1;
   logic [3:0] w0, w1;

   chrono_chain u0 (
      .clk(clk), .rst(rst), .tick_i(tick0), .active_low_i(pol0),
      .hund_o(h0), .sec_o(s0), .min_o(m0), .hr_o(r0), .wrapped_o(w0));

   chrono_chain #(.HUND_MOD(4), .SEC_MOD(3), .MIN_MOD(3), .HR_MOD(24)) u1 (
      .clk(clk), .rst(rst), .tick_i(tick1), .active_low_i(pol1),
      .hund_o(h1), .sec_o(s1), .min_o(m1), .hr_o(r1), .wrapped_o(w1));

   int checks = 0, errors = 0;
   int tot0 = 0, tot1 = 0;

   function automatic logic [7:0] bcd(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   // expected byte of stage k from a total tick count and the four moduli
   function automatic logic [7:0] exp_val(input int tot, input int a, input int b,
                                          input int c, input int d, input int k);
      int q = tot;
      if (k == 0) return bcd(q % a);
      q = q / a;
      if (k == 1) return bcd(q % b);
      q = q / b;
      if (k == 2) return bcd(q % c);
      q = q / c;
      return bcd(q % d);
   endfunction

   function automatic logic [3:0] exp_flags(input int tot, input int a, input int b,
                                            input int c, input int d);
      logic [3:0] f;
      f[0] = tot >= a;
      f[1] = tot >= a * b;
      f[2] = tot >= a * b * c;
      f[3] = tot >= a * b * c * d;
      return f;
   endfunction

   task automatic chk(input string req, input string what, input logic [7:0] act,
                      input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_u0(input string req);
      logic [7:0] inv = {8{pol0}};
      chk(req, "u0 hund", h0, exp_val(tot0, 100, 60, 60, 24, 0) ^ inv);
      chk(req, "u0 sec",  s0, exp_val(tot0, 100, 60, 60, 24, 1) ^ inv);
      chk(req, "u0 min",  m0, exp_val(tot0, 100, 60, 60, 24, 2) ^ inv);
      chk(req, "u0 hr",   r0, exp_val(tot0, 100, 60, 60, 24, 3) ^ inv);
      chk(req, "u0 flags", {4'b0, w0}, {4'b0, exp_flags(tot0, 100, 60, 60, 24) ^ {4{pol0}}});
   endtask

   task automatic check_u1(input string req);
      logic [7:0] inv = {8{pol1}};
      chk(req, "u1 hund", h1, exp_val(tot1, 4, 3, 3, 24, 0) ^ inv);
      chk(req, "u1 sec",  s1, exp_val(tot1, 4, 3, 3, 24, 1) ^ inv);
      chk(req, "u1 min",  m1, exp_val(tot1, 4, 3, 3, 24, 2) ^ inv);
      chk(req, "u1 hr",   r1, exp_val(tot1, 4, 3, 3, 24, 3) ^ inv);
      chk(req, "u1 flags", {4'b0, w1}, {4'b0, exp_flags(tot1, 4, 3, 3, 24) ^ {4{pol1}}});
   endtask

   // called at a falling edge; drives one cycle, compares at the next falling edge
   task automatic step0(input bit t, input string req);
      tick0 = t;
      @(negedge clk);
      tick0 = 1'b0;
      if (t) tot0++;
      check_u0(req);
   endtask

   task automatic step1(input bit t, input string req);
      tick1 = t;
      @(negedge clk);
      tick1 = 1'b0;
      if (t) tot1++;
      check_u1(req);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      tot0 = 0;
      tot1 = 0;
      check_u0("R1");
      check_u1("R1");
   endtask

   task automatic t_hundredths();
      for (int i = 0; i < 120; i++) step0(1'b1, "R3 R7 R10");
   endtask

   task automatic t_idle();
      for (int i = 0; i < 6; i++) step0(1'b0, "R2");
      for (int i = 0; i < 40; i++) step0(i % 3 == 0, "R2 R10");
   endtask

   task automatic t_seconds();
      while (tot0 < 6150) step0(1'b1, "R4 R7 R8");
      for (int i = 0; i < 5; i++) step0(1'b0, "R8 R2");
   endtask

   task automatic t_polarity();
      pol0 = 1'b1;
      #1;
      check_u0("R9");
      step0(1'b1, "R9");
      step0(1'b0, "R9");
      pol0 = 1'b0;
      #1;
      check_u0("R9");
      @(negedge clk);
   endtask

   task automatic t_day();
      while (tot1 < 863) step1(1'b1, "R5 R6 R7 R8");
      chk("R6", "u1 at top hr",   r1, 8'h23);
      chk("R5", "u1 at top min",  m1, 8'h02);
      chk("R4", "u1 at top sec",  s1, 8'h02);
      chk("R3", "u1 at top hund", h1, 8'h03);
      chk("R8", "u1 flags before day wrap", {4'b0, w1}, 8'h07);
      step1(1'b1, "R6");
      chk("R6", "u1 rollover", {h1 | s1 | m1 | r1}, 8'h00);
      chk("R8", "u1 flags after day wrap", {4'b0, w1}, 8'h0F);
      for (int i = 0; i < 4; i++) step1(1'b0, "R8 R2");
      pol1 = 1'b1;
      #1;
      check_u1("R9");
      @(negedge clk);
      pol1 = 1'b0;
   endtask

   task automatic t_reset_during_polarity();
      pol0 = 1'b1;
      t_reset();
      pol0 = 1'b0;
      #1;
      chk("R1", "u0 flags cleared", {4'b0, w0}, 8'h00);
      chk("R1", "u1 flags cleared", {4'b0, w1}, 8'h00);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      t_reset();
      t_hundredths();
      t_idle();
      t_seconds();
      t_polarity();
      t_day();
      t_reset_during_polarity();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule